// File: doc/BRIEF.md
# Dual-Clock Up/Down Counter

A 4-bit binary counter driven by two separate count lines, one for stepping up and one for stepping down. A step happens on a rising edge of either line, but only while the opposite line rests high. A level-sensitive clear forces the count to zero. An active-low load makes the count follow a parallel data word. Neither depends on any count edge. Clear wins over load, and while either is active, count edges have no effect.

All four control lines are asynchronous to the block. Each is passed through a two-flop synchronizer on a fast system clock, and count edges are found by comparing the synchronized level with its value one cycle earlier. The block has two ripple outputs, carry and borrow, which are active low. Carry falls while the count sits at its maximum and the up line is low. Borrow falls while the count sits at zero and the down line is low. Because these outputs track the low phase of the count line, they can drive the up and down inputs of a following stage directly. Wider counters are built this way with no glue logic.

A change on an input line reaches `count_o` within three system clock cycles: two synchronizer flops, then the count register.

Top module: `ud_counter`

## Requirements
- R1: While `rst_ni` is low, and after it is released with no other stimulus, `count_o` is 0 and both `carry_no` and `borrow_no` are 1.
- R2: A rising edge on `up_i` while `dn_i` is high raises `count_o` by one.
- R3: A rising edge on `dn_i` while `up_i` is high lowers `count_o` by one.
- R4: A rising edge on `up_i` while `dn_i` is low leaves `count_o` unchanged, and so does a rising edge on `dn_i` while `up_i` is low.
- R5: While `clear_i` is high, `count_o` is 0 and count edges have no effect.
- R6: While `load_ni` is low and `clear_i` is low, `count_o` follows `data_i` and count edges have no effect. When both are active, clear wins and `count_o` is 0.
- R7: Counting up from 15 gives 0, and counting down from 0 gives 15.
- R8: `carry_no` is 0 exactly while `count_o` is 15 and the synchronized up line is low. Otherwise it is 1.
- R9: `borrow_no` is 0 exactly while `count_o` is 0 and the synchronized down line is low. Otherwise it is 1.
- R10: Two stages chained from `carry_no` to `up_i` and from `borrow_no` to `dn_i` count as one 8-bit binary counter in both directions, with the second stage holding the upper nibble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used for sampling |
| rst_ni | input | 1 | Active-low asynchronous reset of all flops |
| clear_i | input | 1 | Level clear of the count, active high |
| load_ni | input | 1 | Parallel load enable, active low |
| data_i | input | 4 | Parallel load data |
| up_i | input | 1 | Count-up line; rising edge steps up |
| dn_i | input | 1 | Count-down line; rising edge steps down |
| count_o | output | 4 | Current count |
| carry_no | output | 1 | Active-low carry for chaining |
| borrow_no | output | 1 | Active-low borrow for chaining |

## Verification
Counting is exercised in three ways. Plain pulses on one line while the other idles high show the step direction. Crossed sequences, where one line is held low while the other toggles, show that the gating by the opposite level is honoured. This also shows that the return to idle produces exactly one step. Loads of 15 and 0 followed by single steps separate correct wrap-around from saturation. A second stage fed from carry and borrow, stepped 20 times up and then 5 times down, shows whether the ripple pulses arrive as clean rising edges at the next stage in both directions.

// File: rtl/ud_counter_pkg.sv
package ud_counter_pkg;
  typedef enum logic [2:0] {
    OP_HOLD,
    OP_INC,
    OP_DEC,
    OP_LOAD,
    OP_CLR
  } cnt_op_e;
endpackage

// File: rtl/ud_sync.sv
module ud_sync #(
  parameter int  STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= {STAGES{RST_VAL}};
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/ud_ctl.sv
module ud_ctl
  import ud_counter_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    clr_s_i,
  input  logic    load_ns_i,
  input  logic    up_s_i,
  input  logic    dn_s_i,
  output cnt_op_e op_o
);
  logic up_prev_q, dn_prev_q;
  logic up_rise, dn_rise, inc, dec;

  // previous levels rest high so a line idling high gives no edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      up_prev_q <= 1'b1;
      dn_prev_q <= 1'b1;
    end else begin
      up_prev_q <= up_s_i;
      dn_prev_q <= dn_s_i;
    end
  end

  assign up_rise = up_s_i & ~up_prev_q;
  assign dn_rise = dn_s_i & ~dn_prev_q;
  assign inc     = up_rise & dn_s_i;
  assign dec     = dn_rise & up_s_i;

  always_comb begin
    if (clr_s_i)         op_o = OP_CLR;
    else if (!load_ns_i) op_o = OP_LOAD;
    else if (inc && !dec) op_o = OP_INC;
    else if (dec && !inc) op_o = OP_DEC;
    else                 op_o = OP_HOLD;
  end
endmodule

// File: rtl/ud_cnt_core.sv
module ud_cnt_core
  import ud_counter_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  cnt_op_e      op_i,
  input  logic [W-1:0] data_i,
  input  logic         up_s_i,
  input  logic         dn_s_i,
  output logic [W-1:0] cnt_o,
  output logic         carry_no,
  output logic         borrow_no
);
  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};
  localparam logic [W-1:0] CNT_MIN = '0;
  localparam logic [W-1:0] ONE     = W'(1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         carry_q, borrow_q;

  always_comb begin
    unique case (op_i)
      OP_CLR:  cnt_d = CNT_MIN;
      OP_LOAD: cnt_d = data_i;
      OP_INC:  cnt_d = cnt_q + ONE;
      OP_DEC:  cnt_d = cnt_q - ONE;
      default: cnt_d = cnt_q;
    endcase
  end

  // ripple outputs registered from next state: glitch-free, aligned to count
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= CNT_MIN;
      carry_q  <= 1'b1;
      borrow_q <= 1'b1;
    end else begin
      cnt_q    <= cnt_d;
      carry_q  <= !((cnt_d == CNT_MAX) && !up_s_i);
      borrow_q <= !((cnt_d == CNT_MIN) && !dn_s_i);
    end
  end

  assign cnt_o     = cnt_q;
  assign carry_no  = carry_q;
  assign borrow_no = borrow_q;
endmodule

// File: rtl/ud_counter.sv
module ud_counter
  import ud_counter_pkg::*;
#(
  parameter int W          = 4,
  parameter int SYNC_DEPTH = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         load_ni,
  input  logic [W-1:0] data_i,
  input  logic         up_i,
  input  logic         dn_i,
  output logic [W-1:0] count_o,
  output logic         carry_no,
  output logic         borrow_no
);
  localparam int         N_CTL    = 4;
  // idle levels: clear low, load_n high, up high, down high
  localparam logic [N_CTL-1:0] CTL_IDLE = 4'b1110;

  logic [N_CTL-1:0] ctl_raw, ctl_s;
  logic             clr_s, load_ns, up_s, dn_s;
  cnt_op_e          op;

  assign ctl_raw = {dn_i, up_i, load_ni, clear_i};

  for (genvar i = 0; i < N_CTL; i++) begin : g_sync
    ud_sync #(.STAGES(SYNC_DEPTH), .RST_VAL(CTL_IDLE[i])) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (ctl_raw[i]),
      .q_o   (ctl_s[i])
    );
  end

  assign clr_s   = ctl_s[0];
  assign load_ns = ctl_s[1];
  assign up_s    = ctl_s[2];
  assign dn_s    = ctl_s[3];

  ud_ctl u_ctl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_s_i  (clr_s),
    .load_ns_i(load_ns),
    .up_s_i   (up_s),
    .dn_s_i   (dn_s),
    .op_o     (op)
  );

  ud_cnt_core #(.W(W)) u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .op_i     (op),
    .data_i   (data_i),
    .up_s_i   (up_s),
    .dn_s_i   (dn_s),
    .cnt_o    (count_o),
    .carry_no (carry_no),
    .borrow_no(borrow_no)
  );
endmodule

// File: rtl/ud_counter_chk.sv
module ud_counter_chk #(
  parameter int W = 4
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         clr_s,
  input logic         load_ns,
  input logic [W-1:0] data_i,
  input logic [W-1:0] count_o,
  input logic         carry_no,
  input logic         borrow_no
);
  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};
  localparam logic [W-1:0] ONE     = W'(1);

  // R5
  clr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_s |=> (count_o == '0));

  // R6
  load_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_s && !load_ns) |=> (count_o == $past(data_i)));

  // R2 R3 R7: outside clear and load the count moves by at most one, modulo 2**W
  single_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_s && load_ns) |=> (count_o == $past(count_o) ||
                             count_o == $past(count_o) + ONE ||
                             count_o == $past(count_o) - ONE));

  // R8
  carry_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o != CNT_MAX) |-> carry_no);

  // R9
  borrow_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o != '0) |-> borrow_no);
endmodule

bind ud_counter ud_counter_chk #(.W(W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .clr_s    (clr_s),
  .load_ns  (load_ns),
  .data_i   (data_i),
  .count_o  (count_o),
  .carry_no (carry_no),
  .borrow_no(borrow_no)
);

// File: tb/ud_counter_tb.sv
module ud_counter_tb;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         clear_i = 1'b0;
  logic         load_ni = 1'b1;
  logic [W-1:0] data_i = '0;
  logic         up_i = 1'b1;
  logic         dn_i = 1'b1;
  logic [W-1:0] count_o, hi_count;
  logic         carry_no, borrow_no, hi_carry_n, hi_borrow_n;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  ud_counter #(.W(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .clear_i(clear_i), .load_ni(load_ni),
    .data_i(data_i), .up_i(up_i), .dn_i(dn_i),
    .count_o(count_o), .carry_no(carry_no), .borrow_no(borrow_no)
  );

  // upper stage of the cascade
  ud_counter #(.W(W)) u_hi (
    .clk_i(clk), .rst_ni(rst_ni), .clear_i(clear_i), .load_ni(1'b1),
    .data_i('0), .up_i(carry_no), .dn_i(borrow_no),
    .count_o(hi_count), .carry_no(hi_carry_n), .borrow_no(hi_borrow_n)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_up();
    up_i = 1'b0; wait_cyc(5);
    up_i = 1'b1; wait_cyc(5);
  endtask

  task automatic pulse_dn();
    dn_i = 1'b0; wait_cyc(5);
    dn_i = 1'b1; wait_cyc(5);
  endtask

  task automatic load_val(input logic [W-1:0] v);
    data_i = v; load_ni = 1'b0; wait_cyc(5);
    load_ni = 1'b1; wait_cyc(5);
  endtask

  task automatic t_reset();
    wait_cyc(2);
    check("R1 count in reset", count_o, 0);
    check("R1 carry in reset", carry_no, 1);
    rst_ni = 1'b1;
    wait_cyc(5);
    check("R1 count after reset", count_o, 0);
    check("R1 carry after reset", carry_no, 1);
    check("R1 borrow after reset", borrow_no, 1);
  endtask

  task automatic t_up_down();
    for (int i = 0; i < 3; i++) pulse_up();
    check("R2 three up steps", count_o, 3);
    pulse_dn();
    check("R3 one down step", count_o, 2);
  endtask

  task automatic t_gating();
    load_val(4'd6);
    up_i = 1'b0; wait_cyc(5);
    dn_i = 1'b0; wait_cyc(5);
    dn_i = 1'b1; wait_cyc(5);
    check("R4 down edge with up low", count_o, 6);
    dn_i = 1'b0; wait_cyc(5);
    up_i = 1'b1; wait_cyc(5);
    check("R4 up edge with down low", count_o, 6);
    dn_i = 1'b1; wait_cyc(5);
    check("R3 down edge on return to idle", count_o, 5);
  endtask

  task automatic t_load_clear();
    data_i = 4'd10; load_ni = 1'b0; wait_cyc(5);
    check("R6 load follows data", count_o, 10);
    pulse_up();
    check("R6 up ignored during load", count_o, 10);
    data_i = 4'd5; wait_cyc(5);
    check("R6 count tracks data change", count_o, 5);
    clear_i = 1'b1; wait_cyc(5);
    check("R6 clear wins over load", count_o, 0);
    load_ni = 1'b1; wait_cyc(3);
    pulse_up();
    pulse_dn();
    check("R5 edges ignored during clear", count_o, 0);
    clear_i = 1'b0; wait_cyc(5);
    check("R5 count zero after clear", count_o, 0);
  endtask

  task automatic t_wrap();
    load_val(4'd15);
    pulse_up();
    check("R7 up wrap 15 to 0", count_o, 0);
    pulse_dn();
    check("R7 down wrap 0 to 15", count_o, 15);
  endtask

  task automatic t_ripple();
    load_val(4'd15);
    check("R8 carry high at 15 with up idle", carry_no, 1);
    up_i = 1'b0; wait_cyc(5);
    check("R8 carry low at 15 with up low", carry_no, 0);
    check("R9 borrow high at 15", borrow_no, 1);
    up_i = 1'b1; wait_cyc(5);
    check("R8 carry high after step to 0", carry_no, 1);
    check("R7 count wrapped by carry step", count_o, 0);
    up_i = 1'b0; wait_cyc(5);
    check("R9 borrow high at 0 with up low", borrow_no, 1);
    up_i = 1'b1; wait_cyc(5);
    load_val(4'd0);
    dn_i = 1'b0; wait_cyc(5);
    check("R9 borrow low at 0 with down low", borrow_no, 0);
    check("R8 carry high at 0", carry_no, 1);
    dn_i = 1'b1; wait_cyc(5);
    check("R9 borrow high after step to 15", borrow_no, 1);
    load_val(4'd14);
    up_i = 1'b0; wait_cyc(5);
    check("R8 carry high at 14 with up low", carry_no, 1);
    up_i = 1'b1; wait_cyc(5);
  endtask

  task automatic t_cascade();
    clear_i = 1'b1; wait_cyc(5);
    clear_i = 1'b0; wait_cyc(5);
    check("R10 both stages cleared", {hi_count, count_o}, 0);
    for (int i = 0; i < 20; i++) pulse_up();
    wait_cyc(5);
    check("R10 cascade after 20 up", {hi_count, count_o}, 20);
    for (int i = 0; i < 5; i++) pulse_dn();
    wait_cyc(5);
    check("R10 cascade after 5 down", {hi_count, count_o}, 15);
    check("R10 upper stage borrowed", hi_count, 0);
  endtask

  initial begin
    t_reset();
    t_up_down();
    t_gating();
    t_load_clear();
    t_wrap();
    t_ripple();
    t_cascade();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule